// File: doc/BRIEF.md
# Block Access Guard with Sticky Hiding

This block decides, for every access to a block-organized nonvolatile store, whether the access may proceed. A request gives a block index, a direction (read or write) and a privilege level (supervisor or user). The guard returns a grant or a deny in the same cycle, using the configuration state held in registers. A denied access raises a fault for that cycle and forces the returned read data to zero. A granted read passes the store's data through unchanged.

Each block holds a 2-bit protection code and a hide flag. Both are set through a separate configuration port, and that port can also read them back. A hidden block refuses all traffic until the next reset, and no configuration operation can clear the flag. Block 0 is the master block. Its protection code decides who may change the configuration, and when it is set to supervisor-only it shuts every user access out of the whole module, including the configuration port.

Top module: `blk_guard`

## Requirements
- R1: After reset every protection code is 00 and every hide flag is 0, so all in-range accesses are granted. While both valid inputs are low, both grant outputs and both fault outputs stay low.
- R2: Protection codes: 00 permits reads and writes; 01 permits reads only, at both privilege levels; 10 denies every user access and permits supervisor access; 11 behaves exactly as 10.
- R3: A hidden block denies reads and writes at both privilege levels, whatever its protection code.
- R4: A hide flag stays set through protection writes and all other configuration operations, and is cleared only by reset.
- R5: A hide request for block 0 is granted but has no effect, so block 0 is never hidden.
- R6: When block 0 holds code 10 or 11, every user access to any block is denied, and so is every user configuration operation, including reads.
- R7: A supervisor may always write the configuration. A user may write it only while block 0 holds code 00. While block 0 holds 01, user configuration reads are granted and user configuration writes are denied without changing any state.
- R8: A denied access drives acc_fault_o high in that cycle and acc_rdata_o to zero. A granted read drives store_rdata_i onto acc_rdata_o. A granted write drives acc_rdata_o to zero.
- R9: A block index at or above NUM_BLK is denied on both the access port and the configuration port.
- R10: Configuration opcodes are 00 read (cfg_rdata_o = {hide, prot[1:0]}), 01 set protection from cfg_prot_i, 10 hide, and 11 reserved. The reserved opcode is always denied with cfg_fault_o high. Any denied configuration operation returns zero on cfg_rdata_o.
- R11: Verdicts are combinational in the cycle the request is presented. A configuration change takes effect from the next clock edge, so an access in the same cycle as a configuration write sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access request present |
| acc_sup_i | input | 1 | Access privilege: 1 supervisor, 0 user |
| acc_wr_i | input | 1 | Access direction: 1 write, 0 read |
| acc_blk_i | input | BLK_W | Access block index |
| acc_gnt_o | output | 1 | Access granted |
| acc_fault_o | output | 1 | Access denied (one pulse per denied cycle) |
| store_rdata_i | input | DW | Read data from the store |
| acc_rdata_o | output | DW | Read data returned, zero unless a read is granted |
| cfg_valid_i | input | 1 | Configuration operation present |
| cfg_sup_i | input | 1 | Configuration privilege: 1 supervisor, 0 user |
| cfg_op_i | input | 2 | Configuration opcode |
| cfg_blk_i | input | BLK_W | Configuration target block |
| cfg_prot_i | input | 2 | Protection code for opcode 01 |
| cfg_gnt_o | output | 1 | Configuration operation granted |
| cfg_fault_o | output | 1 | Configuration operation denied |
| cfg_rdata_o | output | 3 | {hide, prot} of the target block on a granted read |

## Verification
The bench builds the guard with NUM_BLK = 5 and DW = 16. A 3-bit index therefore has three codes, 5 to 7, that name no block, and this is what reaches the out-of-range deny path. It is not reachable with the power-of-two default. Five blocks are still enough to hold every protection code, a hidden block and the master block at once. The 16-bit data width keeps the pass-through and zeroing of read data easy to see.

// File: rtl/blk_guard_pkg.sv
package blk_guard_pkg;

  typedef enum logic [1:0] {
    PROT_RW  = 2'b00,
    PROT_RO  = 2'b01,
    PROT_SUP = 2'b10,
    PROT_RSV = 2'b11
  } prot_e;

  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_SETP = 2'b01,
    OP_HIDE = 2'b10,
    OP_BAD  = 2'b11
  } cfg_op_e;

  // master block at 10/11 shuts user mode out of the module
  function automatic logic user_locked(logic [1:0] p0);
    return p0[1];
  endfunction

  function automatic logic prot_allows(logic [1:0] p, logic sup, logic wr);
    logic ok;
    case (p)
      PROT_RW: ok = 1'b1;
      PROT_RO: ok = !wr;
      default: ok = sup;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/blk_guard_store.sv
module blk_guard_store #(
  parameter int NUM_BLK = 32,
  parameter int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_prot_i,
  input  logic                   set_hide_i,
  input  logic [BLK_W-1:0]       idx_i,
  input  logic [1:0]             prot_i,
  output logic [2*NUM_BLK-1:0]   prot_o,
  output logic [NUM_BLK-1:0]     hide_o
);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic       hit;
    logic [1:0] prot_r;

    assign hit = (idx_i == BLK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                prot_r <= 2'b00;
      else if (set_prot_i && hit) prot_r <= prot_i;
    end
    assign prot_o[2*b +: 2] = prot_r;

    if (b == 0) begin : g_master
      assign hide_o[b] = 1'b0;
    end else begin : g_hideable
      logic hide_r;
      // set-only: nothing but reset clears it
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                hide_r <= 1'b0;
        else if (set_hide_i && hit) hide_r <= 1'b1;
      end
      assign hide_o[b] = hide_r;
    end
  end

endmodule

// File: rtl/blk_guard_sel.sv
module blk_guard_sel #(
  parameter int NUM_BLK = 32,
  parameter int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic [BLK_W-1:0]     idx_i,
  input  logic [2*NUM_BLK-1:0] prot_vec_i,
  input  logic [NUM_BLK-1:0]   hide_vec_i,
  output logic [1:0]           prot_o,
  output logic                 hide_o,
  output logic                 in_range_o
);

  always_comb begin
    prot_o     = 2'b00;
    hide_o     = 1'b0;
    in_range_o = 1'b0;
    for (int b = 0; b < NUM_BLK; b++) begin
      if (idx_i == BLK_W'(b)) begin
        prot_o     = prot_vec_i[2*b +: 2];
        hide_o     = hide_vec_i[b];
        in_range_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/blk_guard_acc.sv
module blk_guard_acc #(
  parameter int DW = 32
) (
  input  logic          valid_i,
  input  logic          sup_i,
  input  logic          wr_i,
  input  logic [1:0]    prot_i,
  input  logic          hide_i,
  input  logic          in_range_i,
  input  logic [1:0]    prot0_i,
  input  logic [DW-1:0] store_rdata_i,
  output logic          gnt_o,
  output logic          fault_o,
  output logic [DW-1:0] rdata_o
);
  import blk_guard_pkg::*;

  logic ok;

  always_comb begin
    ok = in_range_i && !hide_i;
    if (!sup_i && user_locked(prot0_i)) ok = 1'b0;
    if (!prot_allows(prot_i, sup_i, wr_i)) ok = 1'b0;
  end

  assign gnt_o   = valid_i && ok;
  assign fault_o = valid_i && !ok;
  assign rdata_o = (gnt_o && !wr_i) ? store_rdata_i : '0;

endmodule

// File: rtl/blk_guard_cfg.sv
module blk_guard_cfg #(
  parameter int BLK_W = 5
) (
  input  logic             valid_i,
  input  logic             sup_i,
  input  logic [1:0]       op_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [1:0]       prot_i,
  input  logic             hide_i,
  input  logic             in_range_i,
  input  logic [1:0]       prot0_i,
  output logic             gnt_o,
  output logic             fault_o,
  output logic [2:0]       rdata_o,
  output logic             set_prot_o,
  output logic             set_hide_o
);
  import blk_guard_pkg::*;

  logic locked, may_write, ok;

  assign locked    = !sup_i && user_locked(prot0_i);
  assign may_write = sup_i || (prot0_i == PROT_RW);

  always_comb begin
    case (op_i)
      OP_READ:          ok = in_range_i && !locked;
      OP_SETP, OP_HIDE: ok = in_range_i && may_write;
      default:          ok = 1'b0;
    endcase
  end

  assign gnt_o      = valid_i && ok;
  assign fault_o    = valid_i && !ok;
  assign set_prot_o = gnt_o && (op_i == OP_SETP);
  // hide on the master block is acked and dropped
  assign set_hide_o = gnt_o && (op_i == OP_HIDE) && (blk_i != '0);
  assign rdata_o    = (gnt_o && op_i == OP_READ) ? {hide_i, prot_i} : 3'b000;

endmodule

// File: rtl/blk_guard.sv
module blk_guard #(
  parameter int NUM_BLK = 32,
  parameter int BLK_W   = $clog2(NUM_BLK),
  parameter int DW      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_sup_i,
  input  logic             acc_wr_i,
  input  logic [BLK_W-1:0] acc_blk_i,
  output logic             acc_gnt_o,
  output logic             acc_fault_o,
  input  logic [DW-1:0]    store_rdata_i,
  output logic [DW-1:0]    acc_rdata_o,
  input  logic             cfg_valid_i,
  input  logic             cfg_sup_i,
  input  logic [1:0]       cfg_op_i,
  input  logic [BLK_W-1:0] cfg_blk_i,
  input  logic [1:0]       cfg_prot_i,
  output logic             cfg_gnt_o,
  output logic             cfg_fault_o,
  output logic [2:0]       cfg_rdata_o
);

  logic [2*NUM_BLK-1:0] prot_flat;
  logic [NUM_BLK-1:0]   hide_q;
  logic                 set_prot, set_hide;
  logic [1:0]           acc_prot, cfg_prot_sel;
  logic                 acc_hide, cfg_hide, acc_in, cfg_in;

  blk_guard_store #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_store (
    .clk_i, .rst_ni,
    .set_prot_i (set_prot),
    .set_hide_i (set_hide),
    .idx_i      (cfg_blk_i),
    .prot_i     (cfg_prot_i),
    .prot_o     (prot_flat),
    .hide_o     (hide_q)
  );

  blk_guard_sel #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_acc_sel (
    .idx_i      (acc_blk_i),
    .prot_vec_i (prot_flat),
    .hide_vec_i (hide_q),
    .prot_o     (acc_prot),
    .hide_o     (acc_hide),
    .in_range_o (acc_in)
  );

  blk_guard_sel #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_cfg_sel (
    .idx_i      (cfg_blk_i),
    .prot_vec_i (prot_flat),
    .hide_vec_i (hide_q),
    .prot_o     (cfg_prot_sel),
    .hide_o     (cfg_hide),
    .in_range_o (cfg_in)
  );

  blk_guard_acc #(.DW(DW)) u_acc (
    .valid_i       (acc_valid_i),
    .sup_i         (acc_sup_i),
    .wr_i          (acc_wr_i),
    .prot_i        (acc_prot),
    .hide_i        (acc_hide),
    .in_range_i    (acc_in),
    .prot0_i       (prot_flat[1:0]),
    .store_rdata_i (store_rdata_i),
    .gnt_o         (acc_gnt_o),
    .fault_o       (acc_fault_o),
    .rdata_o       (acc_rdata_o)
  );

  blk_guard_cfg #(.BLK_W(BLK_W)) u_cfg (
    .valid_i    (cfg_valid_i),
    .sup_i      (cfg_sup_i),
    .op_i       (cfg_op_i),
    .blk_i      (cfg_blk_i),
    .prot_i     (cfg_prot_sel),
    .hide_i     (cfg_hide),
    .in_range_i (cfg_in),
    .prot0_i    (prot_flat[1:0]),
    .gnt_o      (cfg_gnt_o),
    .fault_o    (cfg_fault_o),
    .rdata_o    (cfg_rdata_o),
    .set_prot_o (set_prot),
    .set_hide_o (set_hide)
  );

endmodule

// File: rtl/blk_guard_chk.sv
module blk_guard_chk #(
  parameter int NUM_BLK = 32,
  parameter int BLK_W   = $clog2(NUM_BLK),
  parameter int DW      = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_sup_i,
  input logic [BLK_W-1:0] acc_blk_i,
  input logic             acc_gnt_o,
  input logic             acc_fault_o,
  input logic [DW-1:0]    acc_rdata_o,
  input logic             cfg_valid_i,
  input logic             cfg_sup_i,
  input logic [1:0]       cfg_op_i,
  input logic             cfg_fault_o,
  input logic [NUM_BLK-1:0] hide_i,
  input logic [1:0]       prot0_i
);

  logic hid_sel;
  always_comb begin
    hid_sel = 1'b0;
    for (int b = 0; b < NUM_BLK; b++)
      if (acc_blk_i == BLK_W'(b)) hid_sel = hide_i[b];
  end

  assert_hidden_deny_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && hid_sel) |-> !acc_gnt_o);

  assert_hide_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((hide_i & $past(hide_i)) == $past(hide_i)));

  assert_master_visible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hide_i[0]);

  assert_user_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_sup_i && prot0_i[1]) |-> !acc_gnt_o);

  assert_cfg_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && !cfg_sup_i && (cfg_op_i == 2'b01 || cfg_op_i == 2'b10) && prot0_i != 2'b00)
      |-> cfg_fault_o);

  assert_fault_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o |-> (!acc_gnt_o && acc_rdata_o == '0));

  assert_oob_deny_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && 32'(acc_blk_i) >= NUM_BLK) |-> acc_fault_o);

  assert_rsv_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && cfg_op_i == 2'b11) |-> cfg_fault_o);

endmodule

bind blk_guard blk_guard_chk #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_sup_i   (acc_sup_i),
  .acc_blk_i   (acc_blk_i),
  .acc_gnt_o   (acc_gnt_o),
  .acc_fault_o (acc_fault_o),
  .acc_rdata_o (acc_rdata_o),
  .cfg_valid_i (cfg_valid_i),
  .cfg_sup_i   (cfg_sup_i),
  .cfg_op_i    (cfg_op_i),
  .cfg_fault_o (cfg_fault_o),
  .hide_i      (hide_q),
  .prot0_i     (prot_flat[1:0])
);

// File: tb/blk_guard_test.sv
module blk_guard_test;

  localparam int NB = 5;
  localparam int BW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic acc_valid_i = 0, acc_sup_i = 0, acc_wr_i = 0;
  logic [BW-1:0] acc_blk_i = '0;
  logic acc_gnt_o, acc_fault_o;
  logic [DW-1:0] store_rdata_i, acc_rdata_o;
  logic cfg_valid_i = 0, cfg_sup_i = 0;
  logic [1:0] cfg_op_i = '0, cfg_prot_i = '0;
  logic [BW-1:0] cfg_blk_i = '0;
  logic cfg_gnt_o, cfg_fault_o;
  logic [2:0] cfg_rdata_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign store_rdata_i = {8'hC3, 5'b0, acc_blk_i};

  blk_guard #(.NUM_BLK(NB), .BLK_W(BW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni,
    .acc_valid_i, .acc_sup_i, .acc_wr_i, .acc_blk_i, .acc_gnt_o, .acc_fault_o,
    .store_rdata_i, .acc_rdata_o,
    .cfg_valid_i, .cfg_sup_i, .cfg_op_i, .cfg_blk_i, .cfg_prot_i,
    .cfg_gnt_o, .cfg_fault_o, .cfg_rdata_o
  );

  // row: tag, is_cfg, sup, op (bit0 = wr for accesses), blk, prot, exp grant, exp cfg data
  function automatic logic [16:0] v(int tag, bit c, bit s, logic [1:0] op, logic [2:0] b,
                                    logic [1:0] p, bit g, logic [2:0] cd);
    return {4'(tag), c, s, op, b, p, g, cd};
  endfunction

  localparam int NV = 40;
  localparam logic [16:0] VEC [NV] = '{
    v(1,0,0,0,1,0,1,0),  // R1 user read
    v(1,0,0,1,4,0,1,0),  // R1 user write
    v(1,1,0,0,3,0,1,0),  // R1 cfg read, all clear
    v(7,1,0,1,2,1,1,0),  // R7 user sets blk2=RO, master RW
    v(2,0,0,1,2,0,0,0),  // R2 RO user write
    v(2,0,1,1,2,0,0,0),  // R2 RO sup write
    v(2,0,0,0,2,0,1,0),  // R2 RO user read
    v(2,1,1,1,3,2,1,0),  // R2 blk3=10
    v(2,0,0,0,3,0,0,0),  // R2
    v(2,0,1,1,3,0,1,0),  // R2
    v(2,1,1,1,4,3,1,0),  // R2 blk4=11
    v(2,0,0,0,4,0,0,0),  // R2
    v(2,0,1,0,4,0,1,0),  // R2
    v(3,1,0,2,1,0,1,0),  // R3 user hides blk1
    v(3,0,1,0,1,0,0,0),  // R3
    v(3,0,0,1,1,0,0,0),  // R3
    v(4,1,1,1,1,0,1,0),  // R4 prot write on hidden
    v(4,0,1,0,1,0,0,0),  // R4 still hidden
    v(4,1,1,0,1,0,1,4),  // R4 readback hide=1
    v(5,1,1,2,0,0,1,0),  // R5 hide master
    v(5,1,1,0,0,0,1,0),  // R5 readback not hidden
    v(5,0,0,1,0,0,1,0),  // R5 master still usable
    v(9,0,1,0,5,0,0,0),  // R9
    v(9,1,1,0,7,0,0,0),  // R9
    v(10,1,1,3,2,0,0,0), // R10
    v(7,1,1,1,0,1,1,0),  // R7 master=RO
    v(7,1,0,0,2,0,1,1),  // R7 user cfg read ok
    v(7,1,0,1,2,0,0,0),  // R7 user cfg write denied
    v(7,1,0,0,2,0,1,1),  // R7 unchanged
    v(7,0,0,1,0,0,0,0),  // R7 master RO to data
    v(6,0,0,0,2,0,1,0),  // R6 01 does not lock module
    v(6,1,1,1,0,2,1,0),  // R6 master=10
    v(6,0,0,0,2,0,0,0),  // R6
    v(6,0,0,0,0,0,0,0),  // R6
    v(6,1,0,0,2,0,0,0),  // R6 user cfg read denied
    v(6,0,1,0,2,0,1,0),  // R6 sup fine
    v(6,1,1,1,0,3,1,0),  // R6 master=11
    v(6,0,0,0,2,0,0,0),  // R6
    v(6,1,0,2,3,0,0,0),  // R6 user hide denied
    v(6,1,1,0,3,0,1,2)   // R6 blk3 not hidden
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid_i = 0; cfg_valid_i = 0;
  endtask

  task automatic check_acc(string tag, bit g, bit wr);
    chk({tag, " acc_gnt"}, 32'(acc_gnt_o), 32'(g));
    chk({tag, " acc_fault"}, 32'(acc_fault_o), 32'(!g));
    chk({tag, " acc_rdata"}, 32'(acc_rdata_o), (g && !wr) ? 32'({8'hC3, 5'b0, acc_blk_i}) : 32'd0);
  endtask

  task automatic check_cfg(string tag, bit g, logic [2:0] cd);
    chk({tag, " cfg_gnt"}, 32'(cfg_gnt_o), 32'(g));
    chk({tag, " cfg_fault"}, 32'(cfg_fault_o), 32'(!g));
    chk({tag, " cfg_rdata"}, 32'(cfg_rdata_o), 32'(cd));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: idle outputs and cleared state
    @(negedge clk); #1;
    chk("R1 idle acc_gnt", 32'(acc_gnt_o), 0);
    chk("R1 idle acc_fault", 32'(acc_fault_o), 0);
    chk("R1 idle cfg_fault", 32'(cfg_fault_o), 0);
    for (int b = 0; b < NB; b++) begin
      @(negedge clk);
      cfg_valid_i = 1; cfg_sup_i = 1; cfg_op_i = 2'b00; cfg_blk_i = BW'(b);
      #1 check_cfg("R1 reset cfg", 1, 3'b000);
    end
    idle();

    for (int i = 0; i < NV; i++) begin
      logic [16:0] e;
      string tg;
      e = VEC[i];
      tg = $sformatf("R%0d row%0d", e[16:13], i);
      @(negedge clk);
      idle();
      if (e[12]) begin
        cfg_valid_i = 1; cfg_sup_i = e[11]; cfg_op_i = e[10:9];
        cfg_blk_i = e[8:6]; cfg_prot_i = e[5:4];
        #1 check_cfg(tg, e[3], e[2:0]);
      end else begin
        acc_valid_i = 1; acc_sup_i = e[11]; acc_wr_i = e[9]; acc_blk_i = e[8:6];
        #1 check_acc(tg, e[3], e[9]);
      end
    end

    // R11: access in the cycle of a hide still sees the old state
    @(negedge clk);
    idle();
    cfg_valid_i = 1; cfg_sup_i = 1; cfg_op_i = 2'b10; cfg_blk_i = 3'd3;
    acc_valid_i = 1; acc_sup_i = 1; acc_wr_i = 0; acc_blk_i = 3'd3;
    #1 check_acc("R11 same cycle", 1, 0);
    @(negedge clk);
    cfg_valid_i = 0;
    #1 check_acc("R11 next cycle R3", 0, 0);

    // R4: only reset clears hide
    @(negedge clk);
    idle();
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    acc_valid_i = 1; acc_sup_i = 0; acc_wr_i = 1; acc_blk_i = 3'd1;
    #1 check_acc("R4 after reset", 1, 1);
    @(negedge clk);
    idle();
    cfg_valid_i = 1; cfg_sup_i = 0; cfg_op_i = 2'b00; cfg_blk_i = 3'd1;
    #1 check_cfg("R4 readback after reset", 1, 3'b000);
    @(negedge clk);
    idle();
    finish_run();
  end

endmodule